// File: doc/BRIEF.md
# Dual-Mode Parallel Host Port

This block is a slave parallel port. It lets an external host move 16-bit words into and out of a processor core. The host controls all transfer timing with two asynchronous strobe pins. The core uses a small register interface to reach the input and output data registers, the interrupt mask, a sticky event status register and a configuration register.

A configuration bit sets how the two strobe pins are read:

- **Separate-strobe mode:** pin A is the host write strobe and pin B is the host read strobe.
- **Select-plus-strobe mode:** pin A chooses the direction (high means read) and pin B is the single data strobe.

Both pins pass through a two-flop synchroniser. A transfer completes on the trailing edge of its strobe.

Each completed transfer updates the buffer flags and the status:

- A completed host write sets the input-buffer-full flag.
- A completed host read sets the output-buffer-empty flag.
- Both flags are driven to the host as pacing pins.
- Each event sets a sticky status bit.
- Each event emits a one-cycle interrupt pulse when its mask bit is set.

A pin-select bit hands the shared pins to other peripherals. While the pins belong to another peripheral, this port ignores the strobes, never drives the bus and drives its flag pins low.

Top module: `hostport_top`

## Requirements
- R1: After reset:
  - The configuration register (address 3) reads 0, so the mode is separate-strobe and the port owns the pins.
  - The mask (address 1) and status (address 2) read 0.
  - The input-buffer-full pin is 0 and the output-buffer-empty pin is 1.
  - Both interrupt outputs and the bus enable are 0.
- R2: In separate-strobe mode, a low pulse on pin A is a host write. On its trailing edge the word held on the host data input is stored in the input data register, which the core reads at address 0, and the input-buffer-full flag is set.
- R3: In separate-strobe mode, a low level on pin B is a host read. The output data register drives the host data output, and the bus enable is 1. The trailing edge of pin B sets the output-buffer-empty flag.
- R4: When configuration bit 0 is 1 (select-plus-strobe mode), a low pulse on pin B is a write if pin A is low and a read if pin A is high. A low level on pin A alone starts no transfer.
- R5: Core access to address 0 has two effects:
  - A core read clears input-buffer-full.
  - A core write loads the output data register and clears output-buffer-empty.
- R6: Status bit 0 (write event) and bit 1 (read event) are set by completed transfers and stay set. Each clears only when the core writes 1 to that bit at address 2.
- R7: A completed write pulses the write interrupt for exactly one cycle, and only if mask bit 0 is 1. A completed read does the same with the read interrupt and mask bit 1. Status bits are set whatever the mask.
- R8: When configuration bit 1 is 1, the pins belong to another peripheral:
  - The port ignores both strobes.
  - The bus enable stays 0.
  - Both flag pins and the ownership output are 0.
- R9: The bus enable is 1 only while a read strobe is present on the pins and the port owns them. It drops as soon as the strobe is released.
- R10: Flags, status and interrupts change at the third rising clock edge after a strobe is released, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_addr | input | 2 | Core register address (0 data, 1 mask, 2 status, 3 config) |
| core_wr_en | input | 1 | Core register write strobe |
| core_wdata | input | 16 | Core write data |
| core_rd_en | input | 1 | Core register read strobe |
| core_rdata | output | 16 | Core read data, combinational on core_addr |
| irq_wr | output | 1 | Host-write interrupt pulse |
| irq_rd | output | 1 | Host-read interrupt pulse |
| h_pin_a_n | input | 1 | Host pin A: write strobe or read/write-not select |
| h_pin_b_n | input | 1 | Host pin B: read strobe or common data strobe |
| h_data_in | input | 16 | Host data toward the core |
| h_data_out | output | 16 | Data toward the host |
| h_data_oe | output | 1 | Bus drive enable toward the host |
| h_ibf | output | 1 | Input-buffer-full pacing pin |
| h_obe | output | 1 | Output-buffer-empty pacing pin |
| port_owned | output | 1 | 1 while this port owns the shared pins |

## Verification
The assertions assume the following about the host:

- It holds data and the direction pin stable for the whole strobe.
- It spaces strobes far enough apart that two completions of the same kind never fall on adjacent cycles.
- It does not change the mode or pin ownership in the middle of a strobe.

The bench keeps to these rules. It changes pins only on falling clock edges, holds each strobe low for several cycles and leaves several idle cycles between strobes. It changes configuration only while both pins are idle.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
    parameter int HP_DW = 16;
    parameter int HP_AW = 2;

    localparam logic [HP_AW-1:0] ADDR_DATA = 2'd0;
    localparam logic [HP_AW-1:0] ADDR_MASK = 2'd1;
    localparam logic [HP_AW-1:0] ADDR_STAT = 2'd2;
    localparam logic [HP_AW-1:0] ADDR_CFG  = 2'd3;

    typedef struct packed {
        logic [HP_DW-1:0] in_reg;
        logic [HP_DW-1:0] out_reg;
        logic [HP_DW-1:0] cap;
        logic [1:0]       mask;
        logic [1:0]       stat;
        logic             ibf;
        logic             obe;
        logic             mode;
        logic             pin_sel;
        logic             irq_w;
        logic             irq_r;
    } hp_state_t;
endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= RST_VAL;
                end else if (i == 0) begin
                    stage_q[i] <= din;
                end else begin
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hostport_strobe_decode.sv
module hostport_strobe_decode #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a_n,
    input  logic pin_b_n,
    input  logic mode,
    input  logic owned,
    output logic wr_active,
    output logic wr_done,
    output logic rd_done
);
    logic [1:0] pins_s;
    logic       a_s, b_s;
    logic       rd_active;
    logic       wr_prev_q, rd_prev_q;

    hostport_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_a_n, pin_b_n}),
        .dout (pins_s)
    );

    assign a_s = pins_s[1];
    assign b_s = pins_s[0];

    always_comb begin
        if (mode) begin
            wr_active = owned && !b_s && !a_s;
            rd_active = owned && !b_s &&  a_s;
        end else begin
            wr_active = owned && !a_s;
            rd_active = owned && !b_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_prev_q <= 1'b0;
            rd_prev_q <= 1'b0;
        end else begin
            wr_prev_q <= wr_active;
            rd_prev_q <= rd_active;
        end
    end

    assign wr_done = owned && wr_prev_q && !wr_active;
    assign rd_done = owned && rd_prev_q && !rd_active;
endmodule

// File: rtl/hostport_top.sv
module hostport_top
    import hostport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HP_AW-1:0] core_addr,
    input  logic             core_wr_en,
    input  logic [HP_DW-1:0] core_wdata,
    input  logic             core_rd_en,
    output logic [HP_DW-1:0] core_rdata,
    output logic             irq_wr,
    output logic             irq_rd,
    input  logic             h_pin_a_n,
    input  logic             h_pin_b_n,
    input  logic [HP_DW-1:0] h_data_in,
    output logic [HP_DW-1:0] h_data_out,
    output logic             h_data_oe,
    output logic             h_ibf,
    output logic             h_obe,
    output logic             port_owned
);
    hp_state_t q, d;
    logic wr_active, wr_done, rd_done;
    logic owned;

    assign owned = !q.pin_sel;

    hostport_strobe_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_a_n  (h_pin_a_n),
        .pin_b_n  (h_pin_b_n),
        .mode     (q.mode),
        .owned    (owned),
        .wr_active(wr_active),
        .wr_done  (wr_done),
        .rd_done  (rd_done)
    );

    always_comb begin
        d       = q;
        d.irq_w = 1'b0;
        d.irq_r = 1'b0;

        if (wr_active) d.cap = h_data_in;

        if (core_wr_en) begin
            case (core_addr)
                ADDR_DATA: begin
                    d.out_reg = core_wdata;
                    d.obe     = 1'b0;
                end
                ADDR_MASK: d.mask = core_wdata[1:0];
                ADDR_STAT: d.stat = q.stat & ~core_wdata[1:0];
                default: begin
                    d.mode    = core_wdata[0];
                    d.pin_sel = core_wdata[1];
                end
            endcase
        end

        if (core_rd_en && core_addr == ADDR_DATA) d.ibf = 1'b0;

        if (wr_done) begin
            d.in_reg  = q.cap;
            d.ibf     = 1'b1;
            d.stat[0] = 1'b1;
            d.irq_w   = q.mask[0];
        end
        if (rd_done) begin
            d.obe     = 1'b1;
            d.stat[1] = 1'b1;
            d.irq_r   = q.mask[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.obe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (core_addr)
            ADDR_DATA: core_rdata = q.in_reg;
            ADDR_MASK: core_rdata = {{(HP_DW-2){1'b0}}, q.mask};
            ADDR_STAT: core_rdata = {{(HP_DW-2){1'b0}}, q.stat};
            default:   core_rdata = {{(HP_DW-2){1'b0}}, q.pin_sel, q.mode};
        endcase
    end

    assign h_data_oe  = owned && !h_pin_b_n && (q.mode ? h_pin_a_n : 1'b1);
    assign h_data_out = q.out_reg;
    assign h_ibf      = owned && q.ibf;
    assign h_obe      = owned && q.obe;
    assign port_owned = owned;
    assign irq_wr     = q.irq_w;
    assign irq_rd     = q.irq_r;
endmodule

// File: rtl/hostport_chk.sv
module hostport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_wr,
    input logic       irq_rd,
    input logic       h_data_oe,
    input logic       h_ibf,
    input logic       h_obe,
    input logic [1:0] mask_q,
    input logic [1:0] stat_q,
    input logic       pin_sel_q,
    input logic       ibf_q,
    input logic       core_rd_en,
    input logic [1:0] core_addr,
    input logic       wr_done
);
    a_r7_irq_wr_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |-> mask_q[0]);
    a_r7_irq_rd_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rd |-> mask_q[1]);
    a_r7_irq_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |=> !irq_wr);
    a_r7_irq_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rd |=> !irq_rd);
    a_r6_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wr |-> stat_q[0]) and (irq_rd |-> stat_q[1]));
    a_r8_no_drive_unowned: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel_q |-> !h_data_oe);
    a_r8_flags_released: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel_q |-> (!h_ibf && !h_obe));
    a_r5_read_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_en && core_addr == 2'd0 && !wr_done) |=> !ibf_q);
endmodule

bind hostport_top hostport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_wr    (irq_wr),
    .irq_rd    (irq_rd),
    .h_data_oe (h_data_oe),
    .h_ibf     (h_ibf),
    .h_obe     (h_obe),
    .mask_q    (q.mask),
    .stat_q    (q.stat),
    .pin_sel_q (q.pin_sel),
    .ibf_q     (q.ibf),
    .core_rd_en(core_rd_en),
    .core_addr (core_addr),
    .wr_done   (wr_done)
);

// File: tb/hostport_top_tb.sv
module hostport_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  core_addr = '0;
    logic        core_wr_en = 1'b0;
    logic [15:0] core_wdata = '0;
    logic        core_rd_en = 1'b0;
    logic [15:0] core_rdata;
    logic        irq_wr, irq_rd;
    logic        h_pin_a_n = 1'b1;
    logic        h_pin_b_n = 1'b1;
    logic [15:0] h_data_in = '0;
    logic [15:0] h_data_out;
    logic        h_data_oe, h_ibf, h_obe, port_owned;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hostport_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_addr(core_addr), .core_wr_en(core_wr_en), .core_wdata(core_wdata),
        .core_rd_en(core_rd_en), .core_rdata(core_rdata),
        .irq_wr(irq_wr), .irq_rd(irq_rd),
        .h_pin_a_n(h_pin_a_n), .h_pin_b_n(h_pin_b_n), .h_data_in(h_data_in),
        .h_data_out(h_data_out), .h_data_oe(h_data_oe),
        .h_ibf(h_ibf), .h_obe(h_obe), .port_owned(port_owned)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cwr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        core_addr = a; core_wdata = v; core_wr_en = 1'b1;
        @(negedge clk);
        core_wr_en = 1'b0;
    endtask

    task automatic crd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        core_addr = a; core_rd_en = 1'b1;
        #1 v = core_rdata;
        @(negedge clk);
        core_rd_en = 1'b0;
    endtask

    // peek without side effects (address 1..3 never clear anything)
    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        core_addr = a;
        #1 v = core_rdata;
    endtask

    // wait until the third rising edge after release, then sample
    task automatic after_release();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk(h_ibf == 0, "R1 ibf", h_ibf, 0);
        chk(h_obe == 1, "R1 obe", h_obe, 1);
        chk(h_data_oe == 0 && irq_wr == 0 && irq_rd == 0, "R1 oe/irq", {h_data_oe, irq_wr, irq_rd}, 0);
        chk(port_owned == 1, "R1 owned", port_owned, 1);
        peek(2'd3, v); chk(v == 0, "R1 cfg", v, 0);
        peek(2'd1, v); chk(v == 0, "R1 mask", v, 0);
        peek(2'd2, v); chk(v == 0, "R1 status", v, 0);
    endtask

    task automatic t_sep_write();
        logic [15:0] v;
        @(negedge clk);
        h_data_in = 16'hA5C3; h_pin_a_n = 1'b0;
        repeat (5) @(negedge clk);
        h_pin_a_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(h_ibf == 0, "R10 ibf not early", h_ibf, 0);
        @(posedge clk);
        #1 chk(h_ibf == 1, "R2 ibf set", h_ibf, 1);
        chk(irq_wr == 0, "R7 masked irq", irq_wr, 0);
        h_data_in = 16'h0000;
        crd(2'd0, v); chk(v == 16'hA5C3, "R2 data", v, 16'hA5C3);
        #1 chk(h_ibf == 0, "R5 read clears ibf", h_ibf, 0);
        peek(2'd2, v); chk(v[0] == 1, "R6 write status", v, 1);
    endtask

    task automatic t_irq_write();
        @(negedge clk);
        cwr(2'd1, 16'h0003);
        @(negedge clk);
        h_data_in = 16'h1234; h_pin_a_n = 1'b0;
        repeat (4) @(negedge clk);
        h_pin_a_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(irq_wr == 0, "R10 irq not early", irq_wr, 0);
        @(posedge clk);
        #1 chk(irq_wr == 1, "R7 irq pulse", irq_wr, 1);
        @(posedge clk);
        #1 chk(irq_wr == 0, "R7 irq one cycle", irq_wr, 0);
    endtask

    task automatic t_sep_read();
        cwr(2'd0, 16'hBEEF);
        #1 chk(h_obe == 0, "R5 write clears obe", h_obe, 0);
        chk(h_data_oe == 0, "R9 idle no drive", h_data_oe, 0);
        @(negedge clk);
        h_pin_b_n = 1'b0;
        #1 chk(h_data_oe == 1 && h_data_out == 16'hBEEF, "R3 drive", h_data_out, 16'hBEEF);
        repeat (4) @(negedge clk);
        h_pin_b_n = 1'b1;
        #1 chk(h_data_oe == 0, "R9 release", h_data_oe, 0);
        after_release();
        chk(h_obe == 1, "R3 obe set", h_obe, 1);
        chk(irq_rd == 1, "R7 read irq", irq_rd, 1);
    endtask

    task automatic t_status();
        logic [15:0] v;
        peek(2'd2, v); chk(v == 3, "R6 both sticky", v, 3);
        cwr(2'd2, 16'h0001);
        peek(2'd2, v); chk(v == 2, "R6 clear bit0", v, 2);
        cwr(2'd2, 16'h0002);
        peek(2'd2, v); chk(v == 0, "R6 clear bit1", v, 0);
    endtask

    task automatic t_sel_mode();
        logic [15:0] v;
        cwr(2'd1, 16'h0000);
        cwr(2'd3, 16'h0001);
        // pin A low alone: no transfer
        @(negedge clk); h_pin_a_n = 1'b0;
        repeat (4) @(negedge clk); h_pin_a_n = 1'b1;
        after_release();
        peek(2'd2, v); chk(v == 0, "R4 select alone no event", v, 0);
        // write: A low, B pulse
        @(negedge clk); h_pin_a_n = 1'b0; h_data_in = 16'h0F0F;
        @(negedge clk); h_pin_b_n = 1'b0;
        #1 chk(h_data_oe == 0, "R9 no drive on write", h_data_oe, 0);
        repeat (4) @(negedge clk); h_pin_b_n = 1'b1;
        after_release();
        chk(h_ibf == 1, "R4 write ibf", h_ibf, 1);
        @(negedge clk); h_pin_a_n = 1'b1;
        crd(2'd0, v); chk(v == 16'h0F0F, "R4 write data", v, 16'h0F0F);
        // read: A high, B pulse
        cwr(2'd0, 16'h5555);
        @(negedge clk); h_pin_b_n = 1'b0;
        #1 chk(h_data_oe == 1 && h_data_out == 16'h5555, "R4 read drive", h_data_out, 16'h5555);
        repeat (4) @(negedge clk); h_pin_b_n = 1'b1;
        after_release();
        chk(h_obe == 1, "R4 read obe", h_obe, 1);
        cwr(2'd2, 16'h0003);
    endtask

    task automatic t_unowned();
        logic [15:0] v;
        cwr(2'd1, 16'h0003);
        cwr(2'd3, 16'h0002);
        #1 chk(port_owned == 0 && h_obe == 0 && h_ibf == 0, "R8 pins released",
               {port_owned, h_obe, h_ibf}, 0);
        @(negedge clk); h_pin_b_n = 1'b0;
        #1 chk(h_data_oe == 0, "R8 no drive", h_data_oe, 0);
        repeat (3) @(negedge clk); h_pin_b_n = 1'b1;
        @(negedge clk); h_data_in = 16'hFFFF; h_pin_a_n = 1'b0;
        repeat (4) @(negedge clk); h_pin_a_n = 1'b1;
        after_release();
        chk(irq_wr == 0 && irq_rd == 0, "R8 no irq", {irq_wr, irq_rd}, 0);
        repeat (3) @(negedge clk);
        cwr(2'd3, 16'h0000);
        peek(2'd2, v); chk(v == 0, "R8 no status", v, 0);
        crd(2'd0, v); chk(v == 16'h0F0F, "R8 data kept", v, 16'h0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sep_write();
        t_irq_write();
        repeat (3) @(negedge clk);
        t_sep_read();
        repeat (3) @(negedge clk);
        t_status();
        t_sel_mode();
        t_unowned();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule